// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Assignable Prescaler

This block is the main timer of a small microcontroller. It holds an eight-bit count register that software can load at any time. The register advances from one of two sources. The first is an internal cycle pulse, which fires once every four system clocks. The second is an edge on an external pin, and the active edge is selectable. When the count wraps from FFh to 00h, the block sets a sticky overflow flag. The interrupt controller reads this flag, and software clears it.

A single eight-bit prescaler sits between the two users. A routing bit places it either in front of the timer or on the watchdog tick path.

- When it serves the timer, the timer advances once per 2, 4, 8 and so on up to 256 source pulses, and watchdog ticks pass through undivided.
- When it serves the watchdog, the timer advances on every source pulse, and the prescaler divides the incoming watchdog ticks instead.

The watchdog counter itself and interrupt arbitration are outside this block.

Top module: `tmr_prescale_unit`

## Requirements
- R1: While reset is asserted and right after it, the count reads 00h, the overflow flag reads 0 and the prescaler count is zero.
- R2: With `src_ext`=0 and `psa_wdt`=1, the count advances by one every 4 clocks. The first advance happens on the 4th rising clock edge after reset is released.
- R3: With `psa_wdt`=0, the timer advances once per 2^(n+1) source pulses, where n is the 3-bit `ratio` value (0 gives 2, 7 gives 256). The advance happens on the pulse that completes each group.
- R4: With `src_ext`=1, the count advances on pin edges. `edge_fall`=0 selects rising edges and `edge_fall`=1 selects falling edges. The pin passes through a two-flop synchronizer, so an edge applied before clock edge k is counted at edge k+2. At most one edge is counted per clock, and edges of the other polarity are ignored.
- R5: With `src_ext`=1, internal cycle pulses have no effect on the count.
- R6: A write (`wr_en`=1) loads `wr_data` into the count on that clock edge and overrides any increment due on the same edge.
- R7: A write clears the prescaler count, so the next group of source pulses starts again from zero.
- R8: The overflow flag is set only by an increment that takes the count from FFh to 00h. Writes never set it. Once set, it stays set until cleared.
- R9: `ovf_clr`=1 clears the overflow flag on the next clock edge. If a wrap occurs on that same edge, the set wins.
- R10: With `psa_wdt`=1, `wdt_tick_out` passes one in every 2^(n+1) `wdt_tick_in` pulses. With `psa_wdt`=0, it follows `wdt_tick_in` on every pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ext | input | 1 | 1: count external pin edges, 0: count internal cycles |
| edge_fall | input | 1 | 1: falling pin edges, 0: rising pin edges |
| psa_wdt | input | 1 | 1: prescaler serves watchdog, 0: prescaler serves timer |
| ratio | input | 3 | Prescaler select, divide by 2^(ratio+1) |
| ext_pin | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Software write strobe for the count |
| wr_data | input | 8 | Value to load into the count |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| wdt_tick_in | input | 1 | Tick pulses from the watchdog clock domain (already synchronized) |
| cnt_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow request |
| wdt_tick_out | output | 1 | Watchdog tick after optional division |

## Verification
The embedded assertions check four things on every clock:
- a write lands in the count on the next cycle;
- without a write, the count never moves by more than one;
- the overflow flag rises only across an FFh-to-00h step, and stays set until cleared;
- a divided watchdog tick never appears without an input tick.

The exact timing cannot be expressed as a single-cycle property, so only the bench scenarios show it:
- the four-clock cycle pulse and each prescaler ratio;
- synchronizer latency and edge polarity;
- prescaler restart on a write;
- the set-over-clear priority on the flag.

// File: rtl/tmr_prescale_unit.sv
module tmr_prescale_unit #(
  parameter int CNT_W    = 8,
  parameter int PRE_W    = 8,
  parameter int RATIO_W  = 3,
  parameter int CYC_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_ext,
  input  logic               edge_fall,
  input  logic               psa_wdt,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ext_pin,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic               ovf_clr,
  input  logic               wdt_tick_in,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               ovf_flag,
  output logic               wdt_tick_out
);

  localparam int SH_W = RATIO_W + 1;

  logic [CYC_LOG2-1:0] phase_q;
  logic [2:0]          pin_sync_q;
  logic [PRE_W-1:0]    pre_q;
  logic [PRE_W-1:0]    pre_mask;
  logic [SH_W-1:0]     pre_shift;
  logic                cyc_tick, pin_rise, pin_fall, pin_evt;
  logic                src_pulse, pre_src, pre_full, timer_inc, wrap;

  // internal cycle pulse: one per 2**CYC_LOG2 clocks
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;

  assign cyc_tick = &phase_q;

  // two-flop synchronizer plus one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync_q <= '0;
    else        pin_sync_q <= {pin_sync_q[1:0], ext_pin};

  assign pin_rise  = pin_sync_q[1] & ~pin_sync_q[2];
  assign pin_fall  = ~pin_sync_q[1] & pin_sync_q[2];
  assign pin_evt   = edge_fall ? pin_fall : pin_rise;
  assign src_pulse = src_ext ? pin_evt : cyc_tick;

  // prescaler shared between timer and watchdog paths
  assign pre_shift = {1'b0, ratio} + SH_W'(1);
  assign pre_mask  = ~({PRE_W{1'b1}} << pre_shift);
  assign pre_full  = (pre_q & pre_mask) == pre_mask;
  assign pre_src   = psa_wdt ? wdt_tick_in : src_pulse;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_q <= '0;
    else if (wr_en)   pre_q <= '0;
    else if (pre_src) pre_q <= pre_q + 1'b1;

  assign timer_inc    = psa_wdt ? src_pulse : (src_pulse & pre_full);
  assign wdt_tick_out = psa_wdt ? (wdt_tick_in & pre_full) : wdt_tick_in;

  // count register and sticky overflow
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt_q <= '0;
    else if (wr_en)     cnt_q <= wr_data;
    else if (timer_inc) cnt_q <= cnt_q + 1'b1;

  assign wrap = timer_inc & ~wr_en & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;

  // R6: a write is visible on the next cycle
  assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data));

  // R2/R3/R4: without a write the count holds or steps by exactly one
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R8: flag rises only across an FFh-to-00h step
  assert_ovf_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt_q) == {CNT_W{1'b1}}) && (cnt_q == '0));

  // R8: flag is sticky until cleared
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R10: no watchdog tick out without a tick in
  assert_wdt_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick_out |-> wdt_tick_in);

endmodule

// File: tb/sim_tmr_prescale_unit.sv
`timescale 1ns/1ps
module sim_tmr_prescale_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_ext = 1'b0, edge_fall = 1'b0, psa_wdt = 1'b1;
  logic [2:0] ratio = 3'd0;
  logic       ext_pin = 1'b0, wr_en = 1'b0, ovf_clr = 1'b0, wdt_tick_in = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cnt_q;
  logic       ovf_flag, wdt_tick_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tmr_prescale_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .edge_fall(edge_fall),
    .psa_wdt(psa_wdt), .ratio(ratio), .ext_pin(ext_pin), .wr_en(wr_en),
    .wr_data(wr_data), .ovf_clr(ovf_clr), .wdt_tick_in(wdt_tick_in),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag), .wdt_tick_out(wdt_tick_out));

  typedef struct packed {
    logic        psa;
    logic [2:0]  rat;
    logic [7:0]  pre;
    logic [15:0] k;
    logic [7:0]  cnt;
    logic        ovf;
  } vec_t;

  // k edges after reset release, write of pre on edge 1, internal source
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'd0, 8'h00, 16'd40,   8'h0A, 1'b0},  // R2 undivided
    '{1'b0, 3'd0, 8'h00, 16'd40,   8'h05, 1'b0},  // R3 div 2
    '{1'b0, 3'd2, 8'h00, 16'd100,  8'h03, 1'b0},  // R3 div 8
    '{1'b1, 3'd5, 8'hFE, 16'd12,   8'h01, 1'b1},  // R8 wrap
    '{1'b0, 3'd1, 8'hFF, 16'd16,   8'h00, 1'b1},  // R3 div 4 wrap
    '{1'b0, 3'd7, 8'h00, 16'd1024, 8'h01, 1'b0},  // R3 div 256
    '{1'b0, 3'd7, 8'h00, 16'd1020, 8'h00, 1'b0},  // R3 div 256 short
    '{1'b1, 3'd3, 8'h80, 16'd8,    8'h82, 1'b0}   // R2 from preload
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    step();
    wr_en = 1'b0;
  endtask

  task automatic pin_pulse();
    ext_pin = 1'b1;
    repeat (4) step();
    ext_pin = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int outs;

    // R1 reset state
    do_reset();
    check("R1 count", cnt_q, 8'h00);
    check("R1 ovf", {7'd0, ovf_flag}, 8'h00);

    // table-driven runs: R2 R3 R8
    foreach (VECS[i]) begin
      psa_wdt = VECS[i].psa;
      ratio = VECS[i].rat;
      src_ext = 1'b0;
      do_reset();
      load(VECS[i].pre);
      for (int e = 1; e < int'(VECS[i].k); e++) step();
      check($sformatf("R3 vec%0d count", i), cnt_q, VECS[i].cnt);
      check($sformatf("R8 vec%0d ovf", i), {7'd0, ovf_flag}, {7'd0, VECS[i].ovf});
    end

    // R6 write overrides increment, write of FF sets no flag
    psa_wdt = 1'b1;
    do_reset();
    load(8'hFF);
    step();
    step();
    load(8'h55);
    check("R6 write wins", cnt_q, 8'h55);
    check("R8 no set by write", {7'd0, ovf_flag}, 8'h00);
    repeat (4) step();
    check("R6 resumes", cnt_q, 8'h56);

    // R7 write clears prescaler
    psa_wdt = 1'b0;
    ratio = 3'd1;
    do_reset();
    load(8'h00);
    repeat (11) step();
    load(8'h10);
    repeat (14) step();
    check("R7 no early step", cnt_q, 8'h10);
    step();
    check("R7 step after full group", cnt_q, 8'h11);

    // R9 set wins over clear, then clear works
    psa_wdt = 1'b1;
    do_reset();
    load(8'hFF);
    ovf_clr = 1'b1;
    step();
    step();
    step();
    check("R9 set wins", {7'd0, ovf_flag}, 8'h01);
    step();
    check("R9 clear", {7'd0, ovf_flag}, 8'h00);
    ovf_clr = 1'b0;

    // R4 counter mode rising with latency
    src_ext = 1'b1;
    edge_fall = 1'b0;
    psa_wdt = 1'b1;
    do_reset();
    load(8'h00);
    ext_pin = 1'b1;
    step();
    step();
    check("R4 latency hold", cnt_q, 8'h00);
    step();
    check("R4 rise counted", cnt_q, 8'h01);
    step();
    ext_pin = 1'b0;
    repeat (4) step();
    check("R4 fall ignored in rise mode", cnt_q, 8'h01);
    repeat (4) pin_pulse();
    check("R4 rising count", cnt_q, 8'h05);

    // R4 falling mode
    edge_fall = 1'b1;
    ext_pin = 1'b1;
    repeat (4) step();
    check("R4 rise ignored in fall mode", cnt_q, 8'h05);
    ext_pin = 1'b0;
    repeat (4) step();
    check("R4 fall counted", cnt_q, 8'h06);

    // R5 internal cycles ignored in counter mode
    repeat (40) step();
    check("R5 no internal count", cnt_q, 8'h06);

    // R10 watchdog path
    src_ext = 1'b0;
    psa_wdt = 1'b1;
    ratio = 3'd1;
    do_reset();
    outs = 0;
    for (int p = 0; p < 8; p++) begin
      wdt_tick_in = 1'b1;
      #1;
      if (wdt_tick_out) outs++;
      step();
      wdt_tick_in = 1'b0;
      step();
    end
    check("R10 divided ticks", 8'(outs), 8'd2);
    psa_wdt = 1'b0;
    outs = 0;
    for (int p = 0; p < 8; p++) begin
      wdt_tick_in = 1'b1;
      #1;
      if (wdt_tick_out) outs++;
      step();
      wdt_tick_in = 1'b0;
      step();
    end
    check("R10 pass-through ticks", 8'(outs), 8'd8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule